// File: doc/BRIEF.md
# Dual-Boundary Bias Calibration Sequencer

This block calibrates the bias of an injection-locked oscillator in a low-power wake-up receiver. It drives a 7-bit bias code to an external current-steering DAC. It reads a one-bit comparator decision: a 1 means the envelope of the oscillator output is above the reference, so the oscillator is running. A 0 means the oscillator is silent.

A `start_i` pulse arrives at the beginning of a frame preamble, and two binary searches follow. The first search runs while the preamble carries a run of ones. It finds the boundary code above which the oscillator runs, and its result is the lower bound. The second search runs during the run of zeros that follows. It finds the highest code at which the oscillator stays silent, and its result is the upper bound. When both searches are done, the block applies the midpoint of the two bounds to the DAC. It then pulses `done_o`, and it raises `err_o` if the window between the bounds is empty.

Each trial holds its code for `SETTLE_CYC` clock cycles, so that the envelope detector can settle before the comparator is sampled. The default is one symbol period at 100 kb/s with a 100 MHz clock. Each preamble run must therefore last at least 7 trials.

Top module: `sar_cal_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the block is idle. `code_o` is 64, `busy_o`, `done_o` and `err_o` are 0, and `dlow_o` and `dhigh_o` are 0. A reset during a search returns the block to this state.
- R2: A `start_i` pulse while idle raises `busy_o` on the next cycle. The first trial code is 64, which has only the MSB set.
- R3: Each trial holds its code for `SETTLE_CYC` cycles, and the comparator is then sampled. A comparator value of 1 clears the bit under test, and a value of 0 keeps it. The next lower bit is then set. Bits are tested from bit 6 down to bit 0.
- R4: During the first search, the result is the largest code at which the comparator reads 0. `dlow_o` is this result plus one, saturated at 127. If every code reads 1, the result is 0 and `dlow_o` is 1.
- R5: `dhigh_o` is the largest code at which the comparator reads 0 during the second search. If every code reads 1, it is 0.
- R6: After both searches, `code_o` becomes (`dlow_o` + `dhigh_o`) >> 1, computed with an 8-bit sum. This value is visible in the cycle in which `done_o` is high.
- R7: `err_o` is 1 exactly when `dlow_o` > `dhigh_o`. It is set together with `done_o`, holds until the next accepted start, and clears on that start.
- R8: `done_o` is a one-cycle pulse. It is high 14*`SETTLE_CYC`+1 cycles after the edge that accepts the start, and `busy_o` is 0 in that cycle.
- R9: A `start_i` pulse while `busy_o` is 1 has no effect on the results or on the timing of the searches.
- R10: While idle with no start, `code_o` holds its value whatever the comparator does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start calibration pulse (accepted when idle) |
| cmp_i | input | 1 | Comparator decision, 1 = oscillator running |
| code_o | output | 7 | Bias code to the DAC |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle calibration-complete pulse |
| err_o | output | 1 | Empty window: lower bound above upper bound |
| dlow_o | output | 7 | Registered lower bound from the ones search |
| dhigh_o | output | 7 | Registered upper bound from the zeros search |

## Verification
The bench models the oscillator as a pair of thresholds, one for received ones and one for received zeros, and switches the symbol partway through the second search's first trial.

- A normal wide window shows that the two searches look for opposite edges.
- Thresholds at 0, 1 and 128 push each search to its end codes. They expose the +1 offset, saturation at 127 and the all-oscillating case.
- Inverted and adjacent threshold pairs separate an empty window from a window of a single code, which tests the error flag.
- Start pulses during a search, a reset in the middle of a search, and idle periods with comparator activity show that only the accepted start and the trial timing move the code.

// File: rtl/sar_cal_pkg.sv
// Package: shared types for the bias calibration sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_cal_pkg;

    // Sequencer phase: idle, lower-bound search, upper-bound search, apply.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOW   = 2'd1,
        PH_HIGH  = 2'd2,
        PH_APPLY = 2'd3
    } cal_phase_t;

endpackage

// File: rtl/cal_settle_timer.sv
// Module: down-counter that marks the end of each trial's settling window.
// Assumes: SETTLE_CYC >= 1; load_i restarts a full window of SETTLE_CYC cycles.
module cal_settle_timer #(
    parameter int SETTLE_CYC = 1000,
    parameter int CNT_W      = $clog2(SETTLE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expire_o
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Reload on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/sar_search_reg.sv
// Module: one successive-approximation register with its bit-under-test mask.
// Assumes: the comparator value at step_i is the verdict on the current trial;
//          1 clears the bit under test, 0 keeps it. result_o is that verdict
//          applied to the current trial, valid combinationally.
module sar_search_reg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_i,
    input  logic         step_i,
    input  logic         cmp_i,
    output logic [W-1:0] trial_o,
    output logic [W-1:0] result_o,
    output logic         last_o
);
    localparam logic [W-1:0] TOP_BIT = W'(1) << (W - 1);

    logic [W-1:0] trial_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] decided;

    // Apply the comparator verdict to the bit under test.
    always_comb begin
        decided = cmp_i ? (trial_q & ~mask_q) : trial_q;
    end

    // Start at the MSB, then decide one bit per step and try the next lower one.
    always_ff @(posedge clk) begin
        if (!rst_n || init_i) begin
            trial_q <= TOP_BIT;
            mask_q  <= TOP_BIT;
        end else if (step_i) begin
            if (!mask_q[0]) begin
                trial_q <= decided | (mask_q >> 1);
                mask_q  <= mask_q >> 1;
            end else begin
                trial_q <= decided;
            end
        end
    end

    assign trial_o  = trial_q;
    assign result_o = decided;
    assign last_o   = mask_q[0];
endmodule

// File: rtl/cal_midpoint.sv
// Module: midpoint of the two bounds and the empty-window flag.
// Assumes: purely combinational; the sum is one bit wider than the codes.
module cal_midpoint #(
    parameter int W = 7
) (
    input  logic [W-1:0] low_i,
    input  logic [W-1:0] high_i,
    output logic [W-1:0] mid_o,
    output logic         empty_o
);
    logic [W:0] sum;

    // Widen the bounds, add them and halve the sum.
    always_comb begin
        sum     = {1'b0, low_i} + {1'b0, high_i};
        mid_o   = sum[W:1];
        empty_o = (low_i > high_i);
    end
endmodule

// File: rtl/sar_cal_ctrl.sv
// Module: dual-boundary bias calibration sequencer (top).
// Assumes: a run of ones is received for the first 7 trials after start and a
//          run of zeros for the next 7; cmp_i is 1 when the oscillator runs.
module sar_cal_ctrl #(
    parameter int CODE_W     = 7,
    parameter int SETTLE_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cmp_i,
    output logic [CODE_W-1:0] code_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [CODE_W-1:0] dlow_o,
    output logic [CODE_W-1:0] dhigh_o
);
    import sar_cal_pkg::*;

    localparam logic [CODE_W-1:0] HALF_SCALE = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] FULL_SCALE = '1;

    cal_phase_t        phase_q;
    logic [CODE_W-1:0] app_code_q;
    logic [CODE_W-1:0] dlow_q;
    logic [CODE_W-1:0] dhigh_q;
    logic              err_q;
    logic              done_q;

    logic              go;
    logic              searching;
    logic              expire;
    logic              decide;
    logic              sar_last;
    logic              sar_init;
    logic              timer_load;
    logic [CODE_W-1:0] sar_trial;
    logic [CODE_W-1:0] sar_result;
    logic [CODE_W-1:0] mid_code;
    logic              window_empty;

    // Decode the handshake and the per-trial control strobes.
    always_comb begin
        go         = (phase_q == PH_IDLE) && start_i;
        searching  = (phase_q == PH_LOW) || (phase_q == PH_HIGH);
        decide     = searching && expire;
        sar_init   = go || (decide && (phase_q == PH_LOW) && sar_last);
        timer_load = go || (decide && !((phase_q == PH_HIGH) && sar_last));
    end

    cal_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (timer_load),
        .expire_o (expire)
    );

    sar_search_reg #(.W(CODE_W)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_i   (sar_init),
        .step_i   (decide),
        .cmp_i    (cmp_i),
        .trial_o  (sar_trial),
        .result_o (sar_result),
        .last_o   (sar_last)
    );

    cal_midpoint #(.W(CODE_W)) u_mid (
        .low_i   (dlow_q),
        .high_i  (dhigh_q),
        .mid_o   (mid_code),
        .empty_o (window_empty)
    );

    // Step through the phases and capture the bounds and the applied code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            app_code_q <= HALF_SCALE;
            dlow_q     <= '0;
            dhigh_q    <= '0;
            err_q      <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_LOW;
                        err_q   <= 1'b0;
                    end
                end
                PH_LOW: begin
                    if (decide && sar_last) begin
                        dlow_q  <= (sar_result == FULL_SCALE) ? FULL_SCALE
                                                              : sar_result + 1'b1;
                        phase_q <= PH_HIGH;
                    end
                end
                PH_HIGH: begin
                    if (decide && sar_last) begin
                        dhigh_q <= sar_result;
                        phase_q <= PH_APPLY;
                    end
                end
                default: begin
                    app_code_q <= mid_code;
                    err_q      <= window_empty;
                    done_q     <= 1'b1;
                    phase_q    <= PH_IDLE;
                end
            endcase
        end
    end

    assign code_o  = searching ? sar_trial : app_code_q;
    assign busy_o  = (phase_q != PH_IDLE);
    assign done_o  = done_q;
    assign err_o   = err_q;
    assign dlow_o  = dlow_q;
    assign dhigh_o = dhigh_q;
endmodule

// File: rtl/sar_cal_chk.sv
// Module: property checker for the calibration sequencer, bound to the top.
// Assumes: observes ports only; every property is disabled during reset.
module sar_cal_chk #(
    parameter int CODE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [CODE_W-1:0] code_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [CODE_W-1:0] dlow_o,
    input logic [CODE_W-1:0] dhigh_o
);
    localparam logic [CODE_W-1:0] HALF_SCALE = CODE_W'(1) << (CODE_W - 1);

    AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (code_o == HALF_SCALE)); // R2
    AST_CODE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (code_o >= dlow_o && code_o <= dhigh_o)); // R6
    AST_ERR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (err_o == (dlow_o > dhigh_o))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(code_o)); // R10
endmodule

bind sar_cal_ctrl sar_cal_chk #(.CODE_W(CODE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .code_o  (code_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o),
    .dlow_o  (dlow_o),
    .dhigh_o (dhigh_o)
);

// File: tb/tb_sar_cal_ctrl.sv
// Bench: threshold oscillator model, vector table, then directed corner tests.
module tb_sar_cal_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int S          = 8;
    localparam int NVEC       = 7;
    // thr_ones, thr_zeros, exp_dlow, exp_dhigh, exp_code, exp_err
    localparam int VEC [NVEC][6] = '{
        '{30,  90,  30,  89, 59, 0},
        '{1,   127, 1,   126, 63, 0},
        '{0,   128, 1,   127, 64, 0},
        '{100, 40,  100, 39, 69, 1},
        '{128, 0,   127, 0,  63, 1},
        '{64,  65,  64,  64, 64, 0},
        '{65,  64,  65,  63, 64, 1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       cmp_i;
    logic [6:0] code_o, dlow_o, dhigh_o;
    logic       busy_o, done_o, err_o;

    int  thr_ones  = 0;
    int  thr_zeros = 0;
    bit  sym_one   = 1'b1;
    int  nchk      = 0;
    int  nfail     = 0;
    int  done_k    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Oscillator model: runs when the bias code reaches the threshold for the symbol.
    assign cmp_i = sym_one ? (int'(code_o) >= thr_ones) : (int'(code_o) >= thr_zeros);

    sar_cal_ctrl #(.CODE_W(7), .SETTLE_CYC(S)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
        .code_o(code_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .dlow_o(dlow_o), .dhigh_o(dhigh_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One calibration run; optional start pulse during the search.
    task automatic run_cal(input int t1, input int t0, input bit poke);
        thr_ones  = t1;
        thr_zeros = t0;
        sym_one   = 1'b1;
        done_k    = 0;
        @(negedge clk) start_i = 1'b1;
        for (int k = 1; k <= 16 * S; k++) begin
            @(negedge clk);
            start_i = (poke && (k == 3 * S || k == 9 * S)) ? 1'b1 : 1'b0;
            if (k == 1) begin
                check(busy_o == 1'b1, "R2 busy", int'(busy_o), 1);
                check(code_o == 7'd64, "R2 first trial", int'(code_o), 64);
                check(err_o == 1'b0, "R7 err cleared on start", int'(err_o), 0);
            end
            if (k == S) check(code_o == 7'd64, "R3 trial held", int'(code_o), 64);
            if (k == S + 1)
                check(int'(code_o) == ((64 >= t1) ? 32 : 96), "R3 second trial",
                      int'(code_o), (64 >= t1) ? 32 : 96);
            if (k == 7 * S + S / 2) sym_one = 1'b0;
            if (done_o && done_k == 0) done_k = k;
            if (done_k != 0) break;
        end
        start_i = 1'b0;
        check(done_k == 14 * S + 2, "R8 done latency", done_k, 14 * S + 2);
        check(busy_o == 1'b0, "R8 idle with done", int'(busy_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(code_o == 7'd64, "R1 reset code", int'(code_o), 64);
        check(!busy_o && !done_o && !err_o, "R1 reset flags",
              int'({busy_o, done_o, err_o}), 0);
        check(dlow_o == 7'd0 && dhigh_o == 7'd0, "R1 reset bounds",
              int'(dlow_o) + int'(dhigh_o), 0);
        rst_n = 1'b1;

        // Vector table walk.
        for (int v = 0; v < NVEC; v++) begin
            run_cal(VEC[v][0], VEC[v][1], 1'b0);
            check(int'(dlow_o) == VEC[v][2], "R4 lower bound", int'(dlow_o), VEC[v][2]);
            check(int'(dhigh_o) == VEC[v][3], "R5 upper bound", int'(dhigh_o), VEC[v][3]);
            check(int'(code_o) == VEC[v][4], "R6 midpoint", int'(code_o), VEC[v][4]);
            check(int'(err_o) == VEC[v][5], "R7 err flag", int'(err_o), VEC[v][5]);
        end

        // R7: error held while idle; R10: code held with comparator toggling.
        for (int i = 0; i < 20; i++) begin
            @(negedge clk) sym_one = ~sym_one;
        end
        check(err_o == 1'b1, "R7 err held", int'(err_o), 1);
        check(code_o == 7'd64, "R10 idle hold", int'(code_o), 64);

        // R9: start pulses while busy do not disturb the run.
        run_cal(30, 90, 1'b1);
        check(dlow_o == 7'd30 && dhigh_o == 7'd89, "R9 bounds with start while busy",
              int'(dlow_o) * 1000 + int'(dhigh_o), 30089);
        check(code_o == 7'd59, "R9 code with start while busy", int'(code_o), 59);

        // R1: reset in the middle of a search.
        sym_one = 1'b1;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (3 * S) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check(code_o == 7'd64 && !busy_o, "R1 mid-search reset",
              int'(code_o), 64);
        check(dlow_o == 7'd0 && dhigh_o == 7'd0, "R1 mid-search reset bounds",
              int'(dlow_o) + int'(dhigh_o), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule